// File: doc/BRIEF.md
# Operand Bypass and Load-Use Freeze Unit

This unit sits beside the register file of a five-stage in-order pipeline. For the instruction in the execute stage it picks the source of each of its two operands: the register-file read, the result held in the memory stage, or the result held in the write-back stage. It also watches the instruction in decode. If that instruction reads a register that a load in execute has not yet fetched, it raises a freeze. The freeze holds the fetch/decode register and sends a bubble into execute.

Decode-stage fields come in through the ports. The unit decodes the opcode to learn which source fields are real register reads. It keeps its own execute-stage copy of that information, and that copy is loaded with a bubble whenever a freeze is raised. The memory and write-back stages report their destination register and write enable. Branch resolution and the register file are outside the unit.

Top module: `fwd_unit`

## Requirements
- R1: After a synchronous active-high reset, the execute-stage copy holds no instruction: both selects read 00 and freeze is low until an instruction moves from decode into execute.
- R2: The select codes are 00 = register file, 01 = memory-stage result, 10 = write-back-stage result, and 11 never occurs. A source that is read and matches the memory-stage destination, with that stage's write enable high, selects 01.
- R3: A source that matches only the write-back-stage destination, with that stage's write enable high, selects 10.
- R4: When the memory and write-back stages both match a source, the memory stage (the younger result) wins and the select is 01.
- R5: A stage whose write enable is low is never forwarded from, even when its destination field matches.
- R6: Register x0 is never forwarded, and it never causes a freeze, whether it is the destination or the source.
- R7: Whether a source is read comes from the opcode. Opcode 0110011 reads both fields; 0100011 (store) and 1100011 (branch) read both fields; 0010011, 0000011 (load) and 1100111 (indirect jump) read only rs1 (bits 19:15); all other opcodes read neither. A field that is not read never causes forwarding or a freeze. An example is the rs2 position (bits 24:20) of an immediate-ALU word such as 0x00a08093.
- R8: Freeze is high in the same cycle in which the decode instruction reads a register that matches the nonzero destination of a load (opcode 0000011) in execute. On the next clock edge a bubble enters execute, so in the following cycle both selects read 00 and the held decode instruction no longer freezes.
- R9: After a freeze releases, the dependent instruction in execute receives the load result through write-back forwarding (select 10).
- R10: Freezes can follow one another directly: an instruction released from one freeze may itself be a load that freezes its successor.
- R11: The data operand of a store, both operands of a branch, and the base operand of an indirect jump are real sources for both forwarding and freezing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_opcode | input | 7 | Opcode of the instruction in decode |
| id_rd | input | 5 | Destination field of the instruction in decode |
| id_rs1 | input | 5 | First source field of the instruction in decode |
| id_rs2 | input | 5 | Second source field of the instruction in decode |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register of the write-back-stage instruction |
| wb_reg_write | input | 1 | Write-back-stage instruction writes a register |
| fwd_rs1_sel | output | 2 | Operand source for rs1 of the execute instruction |
| fwd_rs2_sel | output | 2 | Operand source for rs2 of the execute instruction |
| freeze | output | 1 | Hold fetch/decode and insert a bubble into execute |

## Verification
Forwarding and freezing can both be active in one cycle. A load whose own address register was loaded just before can sit in execute and take that address from write-back. In the same cycle, the instruction behind it in decode needs the load's result and must freeze. The bench builds this with chains of dependent loads, and it checks the freeze and the write-back select together in that one cycle. It then checks that the bubble clears both selects in the next cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_AW  = 5;
    localparam int OPC_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;
    typedef logic [OPC_W-1:0]  opcode_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'b00,
        SRC_MEM = 2'b01,
        SRC_WB  = 2'b10
    } fwd_sel_e;

    localparam opcode_t OPC_ALU_RR = 7'b0110011;
    localparam opcode_t OPC_ALU_RI = 7'b0010011;
    localparam opcode_t OPC_LOAD   = 7'b0000011;
    localparam opcode_t OPC_STORE  = 7'b0100011;
    localparam opcode_t OPC_BRANCH = 7'b1100011;
    localparam opcode_t OPC_JMP_IND= 7'b1100111;
    localparam opcode_t OPC_JMP    = 7'b1101111;
    localparam opcode_t OPC_UPPER  = 7'b0110111;
    localparam opcode_t OPC_PCREL  = 7'b0010111;

    // Register usage of one instruction, as it travels from decode to execute.
    typedef struct packed {
        reg_idx_t [NUM_SRC-1:0] src;
        logic     [NUM_SRC-1:0] src_used;
        reg_idx_t               dst;
        logic                   dst_write;
        logic                   is_load;
    } op_use_t;

    localparam op_use_t OP_BUBBLE = '0;

    // Which fields are genuine register accesses for a given opcode.
    function automatic op_use_t classify(opcode_t opc, reg_idx_t rd,
                                         reg_idx_t rs1, reg_idx_t rs2);
        op_use_t u;
        u          = OP_BUBBLE;
        u.src[0]   = rs1;
        u.src[1]   = rs2;
        u.dst      = rd;
        case (opc)
            OPC_ALU_RR:  begin u.src_used = 2'b11; u.dst_write = 1'b1; end
            OPC_ALU_RI:  begin u.src_used = 2'b01; u.dst_write = 1'b1; end
            OPC_LOAD:    begin u.src_used = 2'b01; u.dst_write = 1'b1; u.is_load = 1'b1; end
            OPC_STORE:   u.src_used = 2'b11;
            OPC_BRANCH:  u.src_used = 2'b11;
            OPC_JMP_IND: begin u.src_used = 2'b01; u.dst_write = 1'b1; end
            OPC_JMP, OPC_UPPER, OPC_PCREL: u.dst_write = 1'b1;
            default:     u = OP_BUBBLE;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/fwd_decode.sv
// Turns raw decode-stage fields into a register-usage record.
module fwd_decode
    import fwd_pkg::*;
(
    input  opcode_t  opcode,
    input  reg_idx_t rd,
    input  reg_idx_t rs1,
    input  reg_idx_t rs2,
    output op_use_t  use_o
);
    always_comb use_o = classify(opcode, rd, rs1, rs2);
endmodule

// File: rtl/fwd_ex_shadow.sv
// Execute-stage copy of the usage record; a freeze loads a bubble.
module fwd_ex_shadow
    import fwd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bubble,
    input  op_use_t id_use,
    output op_use_t ex_use
);
    always_ff @(posedge clk) begin
        if (rst || bubble) ex_use <= OP_BUBBLE;
        else               ex_use <= id_use;
    end
endmodule

// File: rtl/fwd_src_select.sv
// Operand source choice for one execute-stage source; the memory stage wins.
module fwd_src_select
    import fwd_pkg::*;
(
    input  reg_idx_t src,
    input  logic     used,
    input  reg_idx_t mem_rd,
    input  logic     mem_wr,
    input  reg_idx_t wb_rd,
    input  logic     wb_wr,
    output fwd_sel_e sel
);
    logic live;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        live    = used && (src != '0);
        hit_mem = live && mem_wr && (mem_rd == src);
        hit_wb  = live && wb_wr  && (wb_rd  == src);
        if (hit_mem)     sel = SRC_MEM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/fwd_load_stall.sv
// Load-use detection between the load in execute and the reader in decode.
module fwd_load_stall
    import fwd_pkg::*;
(
    input  op_use_t ex_use,
    input  op_use_t id_use,
    output logic    stall
);
    logic [NUM_SRC-1:0] dep;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dep
        assign dep[g] = id_use.src_used[g] && (id_use.src[g] == ex_use.dst);
    end

    assign stall = ex_use.is_load && (ex_use.dst != '0) && (|dep);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        id_opcode,
    input  logic [4:0]        id_rd,
    input  logic [4:0]        id_rs1,
    input  logic [4:0]        id_rs2,
    input  logic [4:0]        mem_rd,
    input  logic              mem_reg_write,
    input  logic [4:0]        wb_rd,
    input  logic              wb_reg_write,
    output logic [1:0]        fwd_rs1_sel,
    output logic [1:0]        fwd_rs2_sel,
    output logic              freeze
);
    op_use_t  id_use;
    op_use_t  ex_use;
    fwd_sel_e sel [NUM_SRC];
    logic     stall;

    fwd_decode i_decode (
        .opcode (id_opcode),
        .rd     (id_rd),
        .rs1    (id_rs1),
        .rs2    (id_rs2),
        .use_o  (id_use)
    );

    fwd_load_stall i_stall (
        .ex_use (ex_use),
        .id_use (id_use),
        .stall  (stall)
    );

    fwd_ex_shadow i_shadow (
        .clk    (clk),
        .rst    (rst),
        .bubble (stall),
        .id_use (id_use),
        .ex_use (ex_use)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_src_select i_sel (
            .src    (ex_use.src[g]),
            .used   (ex_use.src_used[g]),
            .mem_rd (mem_rd),
            .mem_wr (mem_reg_write),
            .wb_rd  (wb_rd),
            .wb_wr  (wb_reg_write),
            .sel    (sel[g])
        );
    end

    assign fwd_rs1_sel = sel[0];
    assign fwd_rs2_sel = sel[1];
    assign freeze      = stall;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker (
    input logic       clk,
    input logic       rst,
    input logic [6:0] id_opcode,
    input logic [4:0] id_rd,
    input logic [4:0] mem_rd,
    input logic       mem_reg_write,
    input logic [4:0] wb_rd,
    input logic       wb_reg_write,
    input logic [1:0] fwd_rs1_sel,
    input logic [1:0] fwd_rs2_sel,
    input logic       freeze
);
    // R2
    sel_code_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_rs1_sel != 2'b11) && (fwd_rs2_sel != 2'b11));

    // R5
    mem_sel_source_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_rs1_sel == 2'b01 || fwd_rs2_sel == 2'b01) |-> (mem_reg_write && mem_rd != 5'd0));

    // R6
    wb_sel_source_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_rs1_sel == 2'b10 || fwd_rs2_sel == 2'b10) |-> (wb_reg_write && wb_rd != 5'd0));

    // R8
    freeze_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (fwd_rs1_sel == 2'b00 && fwd_rs2_sel == 2'b00 && !freeze));

    // R8
    freeze_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |-> $past(id_opcode == 7'b0000011 && id_rd != 5'd0 && !freeze));
endmodule

bind fwd_unit fwd_checker i_fwd_checker (
    .clk           (clk),
    .rst           (rst),
    .id_opcode     (id_opcode),
    .id_rd         (id_rd),
    .mem_rd        (mem_rd),
    .mem_reg_write (mem_reg_write),
    .wb_rd         (wb_rd),
    .wb_reg_write  (wb_reg_write),
    .fwd_rs1_sel   (fwd_rs1_sel),
    .fwd_rs2_sel   (fwd_rs2_sel),
    .freeze        (freeze)
);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] id_opcode = 7'b0010011;
    logic [4:0] id_rd = '0, id_rs1 = '0, id_rs2 = '0;
    logic [4:0] mem_rd, wb_rd;
    logic       mem_reg_write, wb_reg_write;
    logic [1:0] fwd_rs1_sel, fwd_rs2_sel;
    logic       freeze;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fwd_unit i_fwd_unit (
        .clk(clk), .rst(rst),
        .id_opcode(id_opcode), .id_rd(id_rd), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .mem_rd(mem_rd), .mem_reg_write(mem_reg_write),
        .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
        .fwd_rs1_sel(fwd_rs1_sel), .fwd_rs2_sel(fwd_rs2_sel), .freeze(freeze)
    );

    // Pipeline around the unit: destination and write flag of each stage.
    logic [4:0] nxt_rd = '0;
    logic       nxt_wr = 1'b0;
    logic [4:0] m_ex_rd, m_mem_rd, m_wb_rd;
    logic       m_ex_wr, m_mem_wr, m_wb_wr;

    always @(posedge clk) begin
        if (rst) begin
            m_ex_rd <= '0; m_mem_rd <= '0; m_wb_rd <= '0;
            m_ex_wr <= 1'b0; m_mem_wr <= 1'b0; m_wb_wr <= 1'b0;
        end else begin
            m_wb_rd  <= m_mem_rd;  m_wb_wr  <= m_mem_wr;
            m_mem_rd <= m_ex_rd;   m_mem_wr <= m_ex_wr;
            m_ex_rd  <= freeze ? 5'd0 : nxt_rd;
            m_ex_wr  <= freeze ? 1'b0 : nxt_wr;
        end
    end

    assign mem_rd = m_mem_rd;  assign mem_reg_write = m_mem_wr;
    assign wb_rd  = m_wb_rd;   assign wb_reg_write  = m_wb_wr;

    function automatic logic [31:0] rr(input logic [4:0] rd, rs1, rs2);
        return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] ri(input logic [4:0] rd, rs1, input logic [11:0] imm);
        return {imm, rs1, 3'b000, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] ld(input logic [4:0] rd, rs1);
        return {12'b0, rs1, 3'b010, rd, 7'b0000011};
    endfunction
    function automatic logic [31:0] st(input logic [4:0] rs2, rs1, imm5);
        return {7'b0, rs2, rs1, 3'b010, imm5, 7'b0100011};
    endfunction
    function automatic logic [31:0] br(input logic [4:0] rs1, rs2);
        return {7'b0, rs2, rs1, 3'b000, 5'd0, 7'b1100011};
    endfunction
    function automatic logic [31:0] jr(input logic [4:0] rd, rs1);
        return {12'b0, rs1, 3'b000, rd, 7'b1100111};
    endfunction

    localparam logic [31:0] NOP = 32'h0000_0013;

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input logic ef, input logic [1:0] ea, input logic [1:0] eb);
        check({tag, " freeze"}, {1'b0, freeze}, {1'b0, ef});
        check({tag, " rs1"}, fwd_rs1_sel, ea);
        check({tag, " rs2"}, fwd_rs2_sel, eb);
    endtask

    // Put a word in decode, then check this cycle's outputs.
    task automatic step(input logic [31:0] w, input logic [4:0] rd, input logic wr,
                        input logic ef, input logic [1:0] ea, input logic [1:0] eb,
                        input string tag);
        @(negedge clk);
        id_opcode = w[6:0]; id_rd = w[11:7]; id_rs1 = w[19:15]; id_rs2 = w[24:20];
        nxt_rd = rd; nxt_wr = wr;
        #2;
        look(tag, ef, ea, eb);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        id_opcode = 7'b0010011; id_rd = '0; id_rs1 = '0; id_rs2 = '0;
        nxt_rd = '0; nxt_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #2;
        look("R1 after reset", 1'b0, 2'b00, 2'b00);
    endtask

    task automatic t_basic_fwd();
        do_reset();
        step(rr(1, 2, 3), 1, 1, 0, 2'b00, 2'b00, "R2 fill");
        step(rr(4, 1, 1), 4, 1, 0, 2'b00, 2'b00, "R2 no freeze after ALU");
        step(rr(5, 1, 4), 5, 1, 0, 2'b01, 2'b01, "R2 mem both");
        step(NOP, 0, 1, 0, 2'b10, 2'b01, "R3 wb rs1 mem rs2");
    endtask

    task automatic t_priority();
        do_reset();
        step(rr(6, 1, 1), 6, 1, 0, 2'b00, 2'b00, "R4 fill a");
        step(rr(6, 2, 2), 6, 1, 0, 2'b00, 2'b00, "R4 fill b");
        step(rr(7, 6, 6), 7, 1, 0, 2'b00, 2'b00, "R4 fill c");
        step(NOP, 0, 1, 0, 2'b01, 2'b01, "R4 mem over wb");
    endtask

    task automatic t_no_write();
        do_reset();
        step(st(5, 6, 5), 5, 0, 0, 2'b00, 2'b00, "R5 store rd-field 5");
        step(rr(8, 5, 9), 8, 1, 0, 2'b00, 2'b00, "R5 fill");
        step(NOP, 0, 1, 0, 2'b00, 2'b00, "R5 wr low not forwarded");
    endtask

    task automatic t_zero();
        do_reset();
        step(rr(0, 1, 2), 0, 1, 0, 2'b00, 2'b00, "R6 write x0");
        step(rr(3, 0, 0), 3, 1, 0, 2'b00, 2'b00, "R6 fill");
        step(NOP, 0, 1, 0, 2'b00, 2'b00, "R6 x0 not forwarded");
        step(ld(0, 1), 0, 1, 0, 2'b00, 2'b00, "R6 load x0");
        step(rr(3, 0, 0), 3, 1, 0, 2'b00, 2'b00, "R6 x0 no freeze");
    endtask

    task automatic t_imm_field();
        do_reset();
        step(ld(10, 2), 10, 1, 0, 2'b00, 2'b00, "R7 load x10");
        step(ri(1, 1, 12'h00a), 1, 1, 0, 2'b00, 2'b00, "R7 imm rs2 no freeze");
        step(NOP, 0, 1, 0, 2'b00, 2'b00, "R7 imm rs2 no forward");
    endtask

    task automatic t_load_chain();
        do_reset();
        step(ld(1, 2), 1, 1, 0, 2'b00, 2'b00, "R8 load x1");
        step(ld(2, 1), 2, 1, 1, 2'b00, 2'b00, "R8 freeze on x1");
        step(ld(2, 1), 2, 1, 0, 2'b00, 2'b00, "R8 bubble released");
        step(rr(3, 2, 1), 3, 1, 1, 2'b10, 2'b00, "R10 second freeze with R9 wb");
        step(rr(3, 2, 1), 3, 1, 0, 2'b00, 2'b00, "R10 bubble released");
        step(NOP, 0, 1, 0, 2'b10, 2'b00, "R9 load result via wb");
    endtask

    task automatic t_store_branch();
        do_reset();
        step(ld(5, 1), 5, 1, 0, 2'b00, 2'b00, "R11 load x5");
        step(st(5, 6, 0), 0, 0, 1, 2'b00, 2'b00, "R11 store data freeze");
        step(st(5, 6, 0), 0, 0, 0, 2'b00, 2'b00, "R11 store released");
        step(NOP, 0, 1, 0, 2'b00, 2'b10, "R11 store data via wb");
        do_reset();
        step(ld(7, 1), 7, 1, 0, 2'b00, 2'b00, "R11 load x7");
        step(br(7, 8), 0, 0, 1, 2'b00, 2'b00, "R11 branch freeze");
        step(br(7, 8), 0, 0, 0, 2'b00, 2'b00, "R11 branch released");
        step(NOP, 0, 1, 0, 2'b10, 2'b00, "R11 branch operand via wb");
        step(ld(9, 1), 9, 1, 0, 2'b00, 2'b00, "R11 load x9");
        step(jr(1, 9), 1, 1, 1, 2'b00, 2'b00, "R11 indirect jump freeze");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic_fwd();
        t_priority();
        t_no_write();
        t_zero();
        t_imm_field();
        t_load_chain();
        t_store_branch();
        finish_run();
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule